// File: doc/BRIEF.md
# USB Root Hub Status and Command Register

This block is the hub-level status and command word of a USB host controller's root hub. Software sees it as one 32-bit location. A read returns the remote-wakeup enable, the synchronized over-current level and a latched over-current change flag. A write is decoded into actions, and every action is write-one-to-act. Some bit positions mean one thing on a read and another on a write. Bit 15 reads the wakeup enable, and writing 1 there sets it. Bit 31 is write-only and clears the enable. Bits 16 and 0 read as 0, and writing 1 to them sends a set-global-power or clear-global-power command to the port logic.

The over-current pin is asynchronous, so it first passes through a two-flop synchronizer. Any change in the synchronized level latches a change flag, and software clears that flag by writing 1 to it. While the controller is in its USB-reset state, the register is held at zero and writes are ignored.

Top module: `rh_status_reg`

## Requirements
- R1: After rst_n is low, all stored state is 0. While usb_reset is high, rdata reads 0 and writes have no effect. When usb_reset falls, the wakeup enable (bit 15) and the change flag (bit 17) read 0.
- R2: A write with bit 31 = 1 clears the wakeup enable. Writing 0 to bit 31 has no effect. Bit 31 always reads 0.
- R3: A write with bit 15 = 1 and bit 31 = 0 sets the wakeup enable, which reads back on bit 15. Writing 0 to bit 15 has no effect. If a write has 1 in both bit 31 and bit 15, the clear wins.
- R4: Bit 1 reads the synchronized over-current pin level, where 1 means over-current. The level shows after the second rising clock edge following a pin change. Bit 1 reads 0 whenever no_ovc_prot or ovc_prot_mode is 1.
- R5: Bit 17 becomes 1 on the third rising edge after the pin changes level. Writing 1 to bit 17 clears it. Writing 0 leaves it unchanged.
- R6: If a change event and a write of 1 to bit 17 fall in the same cycle, bit 17 stays 1.
- R7: A write with bit 16 = 1 and bit 0 = 0 drives set_gpwr high for exactly the cycle of the write, combinationally. Bit 16 always reads 0.
- R8: A write with bit 0 = 1 drives clr_gpwr high for the cycle of the write. Bit 0 always reads 0. set_gpwr and clr_gpwr are never high together.
- R9: Bits 30:18 and 14:2 read 0, and writes to them have no effect.
- R10: A write takes effect only when sel and wr are both 1 and usb_reset is 0. Otherwise there are no command pulses and no state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sel | input | 1 | Register selected by the address decode |
| wr | input | 1 | Write strobe |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data |
| ovc_pin | input | 1 | Asynchronous over-current pin, 1 = over-current |
| no_ovc_prot | input | 1 | Configuration: no over-current protection |
| ovc_prot_mode | input | 1 | Configuration: protection mode select |
| usb_reset | input | 1 | Controller is in its USB-reset state |
| set_gpwr | output | 1 | One-cycle set-global-power command |
| clr_gpwr | output | 1 | One-cycle clear-global-power command |

## Verification
The block holds only two state bits, and both are visible on rdata. A wrong wakeup enable therefore shows on bit 15 on the cycle right after the write that caused it. A change flag that is wrongly set or wrongly cleared shows on bit 17 on the third edge after a pin transition. Faults in the command decode show in the write cycle itself, as a missing pulse, an extra pulse, or both pulses at once on set_gpwr and clr_gpwr. The hardest timing to check is the race between a change event and a write-one-clear, which the bench times to a single cycle.

// File: rtl/rh_status_reg.sv
module rh_status_reg #(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sel,
  input  logic        wr,
  input  logic [31:0] wdata,
  output logic [31:0] rdata,
  input  logic        ovc_pin,
  input  logic        no_ovc_prot,
  input  logic        ovc_prot_mode,
  input  logic        usb_reset,
  output logic        set_gpwr,
  output logic        clr_gpwr
);

  localparam int HIST = SYNC_STAGES + 1;

  logic [HIST-1:0] ovc_q;
  logic            wake_en;
  logic            ovc_chg;
  logic            wr_hit;
  logic            ovc_lvl;
  logic            ovc_evt;
  logic            unused_wbits;

  assign wr_hit  = sel & wr & ~usb_reset;
  assign ovc_lvl = ovc_q[SYNC_STAGES-1];
  assign ovc_evt = ovc_q[SYNC_STAGES-1] ^ ovc_q[SYNC_STAGES];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ovc_q <= '0;
    else        ovc_q <= {ovc_q[HIST-2:0], ovc_pin};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    wake_en <= 1'b0;
    else if (usb_reset)            wake_en <= 1'b0;
    else if (wr_hit && wdata[31])  wake_en <= 1'b0;
    else if (wr_hit && wdata[15])  wake_en <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)                    ovc_chg <= 1'b0;
    else if (usb_reset)            ovc_chg <= 1'b0;
    else if (ovc_evt)              ovc_chg <= 1'b1;
    else if (wr_hit && wdata[17])  ovc_chg <= 1'b0;

  assign set_gpwr = wr_hit & wdata[16] & ~wdata[0];
  assign clr_gpwr = wr_hit & wdata[0];

  assign rdata = usb_reset ? 32'h0 :
                 {14'h0, ovc_chg, 1'b0, wake_en, 13'h0,
                  ovc_lvl & ~no_ovc_prot & ~ovc_prot_mode, 1'b0};

  assign unused_wbits = ^{wdata[30:18], wdata[14:1]};

endmodule

module rh_status_reg_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        sel,
  input logic        wr,
  input logic [31:0] wdata,
  input logic        usb_reset,
  input logic [31:0] rdata,
  input logic        set_gpwr,
  input logic        clr_gpwr
);

  assert_cmd_excl_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(set_gpwr && clr_gpwr));

  assert_set_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    set_gpwr |-> (sel && wr && wdata[16] && !usb_reset));

  assert_clr_needs_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
    clr_gpwr |-> (sel && wr && wdata[0] && !usb_reset));

  assert_wake_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !usb_reset && wdata[15] && !wdata[31]) |=> (usb_reset || rdata[15]));

  assert_wake_clear_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (sel && wr && !usb_reset && wdata[31]) |=> !rdata[15]);

  assert_chg_holds_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (rdata[17] && !usb_reset && !(sel && wr && wdata[17])) |=> (usb_reset || rdata[17]));

  assert_usbreset_exit_R1: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(usb_reset) |-> (!rdata[15] && !rdata[17]));

  assert_reserved_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ((rdata & 32'hFFFD_7FFD) == 32'h0));

endmodule

bind rh_status_reg rh_status_reg_chk chk (
  .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .wdata(wdata),
  .usb_reset(usb_reset), .rdata(rdata), .set_gpwr(set_gpwr), .clr_gpwr(clr_gpwr)
);

// File: tb/rh_status_reg_test.sv
module rh_status_reg_test;
  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n, sel, wr, ovc_pin, no_ovc_prot, ovc_prot_mode, usb_reset;
  logic [31:0] wdata, rdata;
  logic        set_gpwr, clr_gpwr;
  int          checks = 0, fails = 0;
  logic        m_wake, m_chg;

  rh_status_reg uut (
    .clk(clk), .rst_n(rst_n), .sel(sel), .wr(wr), .wdata(wdata), .rdata(rdata),
    .ovc_pin(ovc_pin), .no_ovc_prot(no_ovc_prot), .ovc_prot_mode(ovc_prot_mode),
    .usb_reset(usb_reset), .set_gpwr(set_gpwr), .clr_gpwr(clr_gpwr)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(logic lvl);
    if (usb_reset) return 32'h0;
    return {14'h0, m_chg, 1'b0, m_wake, 13'h0, lvl & ~no_ovc_prot & ~ovc_prot_mode, 1'b0};
  endfunction

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic cycle(logic s, logic w, logic [31:0] d, logic ur, string tag);
    logic hit;
    sel = s; wr = w; wdata = d; usb_reset = ur;
    #1;
    hit = s & w & ~ur;
    chk({tag, " R7 set_gpwr"}, {31'h0, set_gpwr}, {31'h0, hit & d[16] & ~d[0]});
    chk({tag, " R8 clr_gpwr"}, {31'h0, clr_gpwr}, {31'h0, hit & d[0]});
    if (ur) chk({tag, " R1 rdata in usb reset"}, rdata, 32'h0);
    @(posedge clk);
    if (ur) begin m_wake = 1'b0; m_chg = 1'b0; end
    else if (hit) begin
      if (d[31]) m_wake = 1'b0; else if (d[15]) m_wake = 1'b1;
      if (d[17]) m_chg = 1'b0;
    end
    #1;
    sel = 1'b0; wr = 1'b0; wdata = 32'h0; usb_reset = 1'b0;
    #1;
    chk({tag, " R2/R3/R5/R9 rdata"}, rdata, exp_rd(ovc_pin));
  endtask

  initial begin
    #(200000 * 4);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst_n = 1'b0; sel = 1'b0; wr = 1'b0; wdata = 32'h0; ovc_pin = 1'b0;
    no_ovc_prot = 1'b0; ovc_prot_mode = 1'b0; usb_reset = 1'b0;
    m_wake = 1'b0; m_chg = 1'b0;
    tick(); tick();
    chk("R1 reset rdata", rdata, 32'h0);
    rst_n = 1'b1;
    tick();
    chk("R1 after reset", rdata, 32'h0);

    cycle(1, 1, 32'h0000_8000, 0, "R3 set wake");
    chk("R3 wake reads 1", {31'h0, rdata[15]}, 32'h1);
    cycle(1, 1, 32'h0000_0000, 0, "R3 write 0 no effect");
    cycle(1, 1, 32'h8000_8000, 0, "R3 clear wins");
    chk("R3 clear wins bit15", {31'h0, rdata[15]}, 32'h0);
    cycle(1, 1, 32'h0000_8000, 0, "R3 set again");
    cycle(1, 1, 32'h8000_0000, 0, "R2 clear wake");
    chk("R2 bit31 and bit15 read 0", rdata & 32'h8000_8000, 32'h0);
    cycle(1, 1, 32'h0001_0000, 0, "R7 set pulse");
    cycle(1, 1, 32'h0000_0001, 0, "R8 clr pulse");
    cycle(1, 1, 32'h0001_0001, 0, "R8 both only clr");
    cycle(1, 1, 32'h7FFC_7FFE, 0, "R9 reserved write");
    cycle(0, 1, 32'h0001_8001, 0, "R10 no sel");
    cycle(1, 0, 32'h0001_8001, 0, "R10 no wr");
    cycle(1, 1, 32'h0001_8001, 1, "R10 write in usb reset");

    ovc_pin = 1'b1;
    tick();
    chk("R4 level after 1 edge", {31'h0, rdata[1]}, 32'h0);
    tick();
    chk("R4 level after 2 edges", {31'h0, rdata[1]}, 32'h1);
    chk("R5 flag after 2 edges", {31'h0, rdata[17]}, 32'h0);
    tick();
    chk("R5 flag after 3 edges", {31'h0, rdata[17]}, 32'h1);
    m_chg = 1'b1;
    no_ovc_prot = 1'b1; #1;
    chk("R4 gated by no_ovc_prot", {31'h0, rdata[1]}, 32'h0);
    no_ovc_prot = 1'b0; ovc_prot_mode = 1'b1; #1;
    chk("R4 gated by ovc_prot_mode", {31'h0, rdata[1]}, 32'h0);
    ovc_prot_mode = 1'b0; #1;
    cycle(1, 1, 32'h0000_0000, 0, "R5 write 0 keeps flag");
    cycle(1, 1, 32'h0002_0000, 0, "R5 write 1 clears flag");

    ovc_pin = 1'b0;
    tick(); tick();
    sel = 1'b1; wr = 1'b1; wdata = 32'h0002_0000;
    @(posedge clk); #1;
    sel = 1'b0; wr = 1'b0; wdata = 32'h0;
    chk("R6 event beats clear", {31'h0, rdata[17]}, 32'h1);
    m_chg = 1'b1;
    cycle(1, 1, 32'h0002_0000, 0, "R5 clear after race");

    cycle(1, 1, 32'h0000_8000, 0, "R1 prep wake");
    ovc_pin = 1'b1;
    tick(); tick(); tick();
    m_chg = 1'b1;
    chk("R1 prep flag", {31'h0, rdata[17]}, 32'h1);
    cycle(0, 0, 32'h0, 1, "R1 usb reset clears");

    for (int i = 0; i < 400; i++) begin
      logic [31:0] d;
      d = $urandom;
      if (($urandom % 4) == 0) d = d & 32'h8003_8001;
      cycle(($urandom % 4) != 0, ($urandom % 4) != 0, d, ($urandom % 16) == 0, "random");
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule